// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a three-wire link to a 16-bit sampling converter. The wires are an active-low chip select, a data clock and a serial data line. A one-cycle start request makes the controller drop chip select and run a fixed number of data-clock periods. The clock is made from the system clock by a divider. The converter changes its data line after each falling clock edge. The controller takes one sample of the line for each rising edge.

The first five periods of a frame are the converter's input sampling window and carry nothing useful. The sixth sampled bit is a null bit that should read low. The next sixteen bits form the unsigned result, most significant bit first: 0x0000 is zero scale, 0x8000 is midscale and 0xFFFF is full scale. In the long frame the converter then sends the word again, least significant bit first. The last bit of the first copy serves as the first bit of the echo, so the echo adds bits 1 through 15. The controller checks each echo bit against the word it has already assembled. A mismatch, or a high null bit, sets an error flag for that frame. When the last clock period ends, chip select goes high. The controller waits one more full clock period and then pulses valid with the result and the error flag.

Top module: `serial_adc_reader`

## Requirements
- R1: After reset, chip select is high, the data clock is low, busy and valid are low, and the result and error outputs are zero.
- R2: In the cycle after a start request is accepted while idle, chip select is low and busy is high. Busy stays high until the cycle that carries the valid pulse.
- R3: With the frame-length input at 0 when the request is accepted, the frame has exactly 22 rising data-clock edges while chip select is low. With it at 1, the frame has exactly 37.
- R4: Each high and low half of the data clock lasts DIV_HALF system cycles, so rising edges are 2*DIV_HALF cycles apart. The data clock is low whenever chip select is high.
- R5: The bits taken on rising edges 1 to 5 are ignored and do not affect the result, even when they are high.
- R6: The bits taken on rising edges 7 to 22 form the result, the first of them as bit 15 and the last as bit 0.
- R7: In a long frame, the bit taken on rising edge 22+k (k = 1..15) must equal result bit k. Any difference sets the error output that comes with valid. A frame that starts later with a clean echo reports no error.
- R8: A high bit taken on rising edge 6 (the null bit) sets the error output in either frame length.
- R9: Chip select stays high for at least 2*DIV_HALF system cycles between the end of one frame and the start of the next.
- R10: A start request that arrives while busy is ignored: the running frame continues unchanged and no new frame begins.
- R11: Valid is a single-cycle pulse. Result and error hold their values while the block is idle.
- R12: The frame length is taken when the request is accepted. Changing the frame-length input during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one conversion readout |
| long_frame_i | input | 1 | 1 selects the 37-clock frame with echo check, 0 the 22-clock frame |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Data clock to the converter |
| busy_o | output | 1 | High from an accepted request until the valid pulse |
| valid_o | output | 1 | One-cycle pulse when a new result is available |
| result_o | output | 16 | Unsigned conversion result |
| err_o | output | 1 | Null bit high or echo mismatch in the reported frame |

## Verification
The converter model drives high bits during the sampling window. Codes for zero, midscale and full scale show whether the window and the null bit leak into the word. An alternating pattern and a code of 0x0001 show bit order, and the second of these also covers the shared LSB at the echo boundary. Echo faults at a middle bit and at the final MSB bit show that every echo position is compared, and a high null bit checks that test separately. A start pulse together with a flip of the frame-length input in mid-frame, followed by back-to-back frames, tells apart a controller that restarts or re-reads its mode from one that ignores both and keeps the chip-select gap.

// File: rtl/serial_adc_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the serial ADC readout controller.
// Assumes: nothing beyond the standard language.
package serial_adc_pkg;

    // Controller sequencing states.
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_RUN  = 2'd1,
        RD_GAP  = 2'd2
    } rd_state_e;

endpackage

// File: rtl/adc_sclk_div.sv
`timescale 1ns/1ps
// Module: adc_sclk_div
// Produces a one-cycle tick every DIV_HALF system cycles while enabled.
// Each tick marks the end of one data-clock half period.
// Assumes: DIV_HALF >= 1. The counter restarts from zero whenever en is low.
module adc_sclk_div #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int HW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [HW-1:0] hcnt_q;

    assign tick = en && (hcnt_q == HW'(DIV_HALF - 1));

    // Half-period counter: held at zero when disabled, wraps on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hcnt_q <= '0;
        end else if (tick) begin
            hcnt_q <= '0;
        end else begin
            hcnt_q <= hcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_frame_capture.sv
`timescale 1ns/1ps
// Module: adc_frame_capture
// Sorts each sampled bit by its rising-edge number within the frame.
// The null bit is checked low, result bits are shifted in MSB first,
// and echo bits are compared against the word already assembled.
// Assumes: edge_num is the 1-based number of the rising edge being sampled.
// clear is pulsed when a new frame is accepted.
module adc_frame_capture #(
    parameter int DATA_W      = 16,
    parameter int SAMPLE_CLKS = 5,
    parameter int CNT_W       = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample_en,
    input  logic [CNT_W-1:0]  edge_num,
    input  logic              sdata_i,
    output logic [DATA_W-1:0] word_o,
    output logic              err_o
);
    localparam int NULL_POS   = SAMPLE_CLKS + 1;
    localparam int FIRST_BIT  = NULL_POS + 1;
    localparam int LAST_SHORT = NULL_POS + DATA_W;
    localparam int LAST_LONG  = LAST_SHORT + DATA_W - 1;
    localparam int IDX_W      = $clog2(DATA_W);

    logic [IDX_W-1:0] echo_idx;
    logic             in_word;
    logic             in_echo;

    assign echo_idx = IDX_W'(edge_num - CNT_W'(LAST_SHORT));
    assign in_word  = (edge_num >= CNT_W'(FIRST_BIT)) && (edge_num <= CNT_W'(LAST_SHORT));
    assign in_echo  = (edge_num >  CNT_W'(LAST_SHORT)) && (edge_num <= CNT_W'(LAST_LONG));

    // Word assembly and sticky error accumulation for the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word_o <= '0;
            err_o  <= 1'b0;
        end else if (sample_en) begin
            if (edge_num == CNT_W'(NULL_POS)) begin
                if (sdata_i) err_o <= 1'b1;
            end else if (in_word) begin
                word_o <= {word_o[DATA_W-2:0], sdata_i};
            end else if (in_echo) begin
                if (sdata_i != word_o[echo_idx]) err_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_adc_reader.sv
`timescale 1ns/1ps
// Module: serial_adc_reader (top)
// Reads one conversion from a three-wire serial converter per accepted
// request. It drives chip select and a divided data clock, samples the data
// line on each rising edge, and reports the result with a valid pulse and
// an error flag.
// Assumes: the converter changes data on falling clock edges. Requests that
// arrive while busy are dropped.
module serial_adc_reader
    import serial_adc_pkg::*;
#(
    parameter int DIV_HALF    = 2,
    parameter int DATA_W      = 16,
    parameter int SAMPLE_CLKS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              long_frame_i,
    input  logic              sdata_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              busy_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic              err_o
);
    localparam int NULL_POS   = SAMPLE_CLKS + 1;
    localparam int LAST_SHORT = NULL_POS + DATA_W;
    localparam int LAST_LONG  = LAST_SHORT + DATA_W - 1;
    localparam int CNT_W      = $clog2(LAST_LONG + 1);

    rd_state_e         state_q;
    logic              tick;
    logic              mode_q;
    logic              gap_q;
    logic [CNT_W-1:0]  edge_q;
    logic [CNT_W-1:0]  edge_next;
    logic [CNT_W-1:0]  last_edge;
    logic              start_ok;
    logic              sample_en;
    logic [DATA_W-1:0] cap_word;
    logic              cap_err;

    assign start_ok  = (state_q == RD_IDLE) && start_i;
    assign edge_next = edge_q + 1'b1;
    assign last_edge = mode_q ? CNT_W'(LAST_LONG) : CNT_W'(LAST_SHORT);
    assign sample_en = (state_q == RD_RUN) && tick && !sclk_o;
    assign busy_o    = (state_q != RD_IDLE);

    adc_sclk_div #(
        .DIV_HALF (DIV_HALF)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q != RD_IDLE),
        .tick  (tick)
    );

    adc_frame_capture #(
        .DATA_W      (DATA_W),
        .SAMPLE_CLKS (SAMPLE_CLKS),
        .CNT_W       (CNT_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_ok),
        .sample_en (sample_en),
        .edge_num  (edge_next),
        .sdata_i   (sdata_i),
        .word_o    (cap_word),
        .err_o     (cap_err)
    );

    // Frame sequencing: select, clock toggling, closing gap and reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RD_IDLE;
            cs_n_o   <= 1'b1;
            sclk_o   <= 1'b0;
            edge_q   <= '0;
            gap_q    <= 1'b0;
            mode_q   <= 1'b0;
            valid_o  <= 1'b0;
            result_o <= '0;
            err_o    <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            case (state_q)
                RD_IDLE: begin
                    if (start_i) begin
                        state_q <= RD_RUN;
                        cs_n_o  <= 1'b0;
                        sclk_o  <= 1'b0;
                        edge_q  <= '0;
                        mode_q  <= long_frame_i;
                    end
                end
                RD_RUN: begin
                    if (tick) begin
                        sclk_o <= !sclk_o;
                        if (!sclk_o) begin
                            edge_q <= edge_next;
                        end else if (edge_q == last_edge) begin
                            cs_n_o  <= 1'b1;
                            gap_q   <= 1'b0;
                            state_q <= RD_GAP;
                        end
                    end
                end
                RD_GAP: begin
                    if (tick) begin
                        if (gap_q) begin
                            state_q  <= RD_IDLE;
                            valid_o  <= 1'b1;
                            result_o <= cap_word;
                            err_o    <= cap_err;
                        end else begin
                            gap_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_reader_chk.sv
`timescale 1ns/1ps
// Module: adc_reader_chk
// Assertion checker bound to serial_adc_reader. It watches only the ports.
// Assumes: synchronous active-low reset on rst_n.
module adc_reader_chk #(
    parameter int DIV_HALF = 2,
    parameter int DATA_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              cs_n_o,
    input logic              sclk_o,
    input logic              busy_o,
    input logic              valid_o,
    input logic [DATA_W-1:0] result_o,
    input logic              err_o
);
    localparam logic [15:0] SAT = 16'hFFFF;

    logic        sclk_d;
    logic [15:0] hold_q;
    logic [15:0] cs_hi_q;

    // Length of the current data-clock level in system cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            hold_q <= SAT;
        end else begin
            sclk_d <= sclk_o;
            if (sclk_o != sclk_d) hold_q <= 16'd1;
            else if (hold_q != SAT) hold_q <= hold_q + 1'b1;
        end
    end

    // Number of consecutive cycles chip select has been high.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_hi_q <= SAT;
        else if (!cs_n_o) cs_hi_q <= '0;
        else if (cs_hi_q != SAT) cs_hi_q <= cs_hi_q + 1'b1;
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o && !cs_n_o);

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && busy_o |=> !$fell(cs_n_o));

    // R4
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R4
    high_half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_o && sclk_d) |-> hold_q == 16'(DIV_HALF));

    // R9
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> cs_hi_q >= 16'(2 * DIV_HALF));

    // R11
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R2
    valid_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !busy_o && $past(busy_o));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && $past(!busy_o) |-> $stable(result_o) && $stable(err_o));
endmodule

bind serial_adc_reader adc_reader_chk #(
    .DIV_HALF (DIV_HALF),
    .DATA_W   (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cs_n_o   (cs_n_o),
    .sclk_o   (sclk_o),
    .busy_o   (busy_o),
    .valid_o  (valid_o),
    .result_o (result_o),
    .err_o    (err_o)
);

// File: tb/tb_serial_adc_reader.sv
`timescale 1ns/1ps
// Directed bench for serial_adc_reader with a behavioural converter model.
module tb_serial_adc_reader;
    localparam int DIV = 2;
    localparam int PER = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        long_frame_i = 1'b0;
    logic        sdata_i;
    logic        cs_n_o, sclk_o, busy_o, valid_o, err_o;
    logic [15:0] result_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Converter model controls
    logic [15:0] m_word = 16'h0;
    logic        m_null = 1'b0;
    int          m_flip = 0;
    int          fcnt = 0;

    // Clock-edge measurements
    int  rcnt = 0;
    int  per_bad = 0;
    bit  have_prev = 0;
    time prev_t = 0;
    int  hi_run = 0;
    int  last_gap = 0;

    always #(PER/2) clk = ~clk;

    serial_adc_reader #(.DIV_HALF(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .long_frame_i(long_frame_i),
        .sdata_i(sdata_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .busy_o(busy_o),
        .valid_o(valid_o), .result_o(result_o), .err_o(err_o)
    );

    // Converter: reset on deselect, launch next bit on each falling clock.
    initial sdata_i = 1'b1;
    always @(negedge sclk_o or posedge cs_n_o) begin
        if (cs_n_o) begin
            fcnt = 0;
            sdata_i = 1'b1;
        end else begin
            fcnt = fcnt + 1;
            if (fcnt < 5) sdata_i = 1'b1;
            else if (fcnt == 5) sdata_i = m_null;
            else if (fcnt <= 21) sdata_i = m_word[21 - fcnt];
            else if (fcnt <= 36) sdata_i = m_word[fcnt - 21] ^ (fcnt == m_flip);
            else sdata_i = 1'b1;
        end
    end

    // Rising-edge count per frame and spacing check.
    always @(posedge sclk_o or negedge cs_n_o) begin
        if (!sclk_o) begin
            rcnt = 0;
            have_prev = 0;
        end else begin
            if (have_prev && ($time - prev_t) != 2 * DIV * PER) per_bad = per_bad + 1;
            prev_t = $time;
            have_prev = 1;
            rcnt = rcnt + 1;
        end
    end

    // Chip-select high run length, recorded when it ends.
    always @(posedge clk) begin
        if (cs_n_o) hi_run <= hi_run + 1;
        else begin
            if (hi_run != 0) last_gap <= hi_run;
            hi_run <= 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_valid(output bit got);
        got = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (valid_o) begin
                got = 1;
                break;
            end
        end
    endtask

    task automatic reset_test();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n_o == 1 && sclk_o == 0 && busy_o == 0 && valid_o == 0,
              "R1", "ctrl", {cs_n_o, sclk_o, busy_o, valid_o}, 4'b1000);
        check(result_o == 0 && err_o == 0, "R1", "result/err",
              {err_o, result_o}, 0);
    endtask

    // One frame; back_to_back also checks the deselect gap before it.
    task automatic frame_test(input logic [15:0] w, input bit lng, input bit nul,
                              input int flip, input bit exp_err,
                              input bit back_to_back, input string req);
        bit got;
        int bad0;
        while (busy_o) @(negedge clk);
        m_word = w; m_null = nul; m_flip = flip;
        bad0 = per_bad;
        long_frame_i = lng;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && !cs_n_o, "R2", "busy/cs after start", {busy_o, cs_n_o}, 2'b10);
        wait_valid(got);
        check(got, "R2", "valid seen", got, 1);
        check(result_o == w, req, "result", result_o, w);
        check(err_o == exp_err, (nul ? "R8" : "R7"), "err", err_o, exp_err);
        check(rcnt == (lng ? 37 : 22), "R3", "rising edges", rcnt, lng ? 37 : 22);
        check(per_bad == bad0, "R4", "clock spacing errors", per_bad - bad0, 0);
        if (back_to_back)
            check(last_gap >= 2 * DIV, "R9", "cs high gap", last_gap, 2 * DIV);
        @(negedge clk);
        check(!valid_o && result_o == w, "R11", "valid pulse/hold",
              {valid_o, result_o}, {1'b0, w});
    endtask

    // Start pulse and mode flip during a long frame are both ignored.
    task automatic busy_ignore_test();
        bit got;
        while (busy_o) @(negedge clk);
        m_word = 16'h5A5A; m_null = 0; m_flip = 0;
        long_frame_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (40) @(negedge clk);
        long_frame_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && !cs_n_o, "R10", "still in frame", {busy_o, cs_n_o}, 2'b10);
        wait_valid(got);
        check(got && result_o == 16'h5A5A && !err_o, "R10", "result after ignored start",
              result_o, 16'h5A5A);
        check(rcnt == 37, "R12", "rising edges after mode flip", rcnt, 37);
        repeat (3) @(negedge clk);
        check(!busy_o && cs_n_o, "R10", "no new frame", {busy_o, cs_n_o}, 2'b01);
    endtask

    initial begin
        #(200000 * PER);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        reset_test();
        frame_test(16'h8000, 0, 0, 0, 0, 0, "R5");   // midscale, window bits high
        frame_test(16'h0000, 0, 0, 0, 0, 1, "R5");   // zero scale
        frame_test(16'hFFFF, 0, 0, 0, 0, 1, "R6");   // full scale
        frame_test(16'hA5C3, 0, 0, 0, 0, 1, "R6");   // bit order
        frame_test(16'h1234, 1, 0, 0, 0, 1, "R7");   // clean echo
        frame_test(16'h1234, 1, 0, 30, 1, 1, "R7");  // echo bit 9 flipped
        frame_test(16'h0001, 1, 0, 0, 0, 1, "R7");   // shared LSB, clean
        frame_test(16'hC001, 1, 0, 36, 1, 1, "R7");  // final echo bit flipped
        frame_test(16'h7FFF, 0, 1, 0, 1, 1, "R8");   // null high, short
        frame_test(16'h7FFF, 1, 1, 0, 1, 1, "R8");   // null high, long
        frame_test(16'h0F0F, 1, 0, 0, 0, 1, "R7");   // error cleared next frame
        busy_ignore_test();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule